// File: doc/BRIEF.md
# Saturating Fractional Fixed-Point Multiplier

This block multiplies two fixed-point operands in one of several arithmetic flavours: a doubled Q15 by Q15 product giving a Q31 value, a doubled Q31 by Q31 product giving a Q63 value, a Q15 result rounded to nearest, a plain signed 16-bit integer product that wraps, and an unsigned 8-bit by 16-bit product that clamps. The datapath is purely combinational, so the result is ready in the same cycle the operands are presented.

The only fractional input pair whose doubled product cannot be represented is minus one times minus one. The block detects it, replaces the result with the largest positive value, and raises an overflow event. Overflow events are captured in sticky status bits when the operation is strobed valid. A fractional product headed for one of the accumulators marks that accumulator's own bit. Every other overflow marks a shared general bit. The accumulation itself and operand fetch live outside this block.

Top module: `fmul_q_sat`

## Requirements
- R1: With mode 0 (Q15 fractional), the result equals the signed product of a_in[15:0] and b_in[15:0] shifted left by one, placed in result[31:0] with result[63:32] zero.
- R2: With mode 0 and both a_in[15:0] and b_in[15:0] equal to 0x8000, result[31:0] is 0x7FFFFFFF and sat_hit is 1.
- R3: With mode 1 (Q31 fractional), the result is the signed 64-bit product of a_in and b_in shifted left by one. When both operands equal 0x80000000, the result is 0x7FFFFFFFFFFFFFFF and sat_hit is 1.
- R4: With mode 2 (rounded Q15), result[15:0] is bits 31:16 of the doubled Q15 product plus 0x8000, and the upper result bits are zero. The 0x8000 by 0x8000 case gives 0x7FFF with sat_hit set.
- R5: With mode 3 (signed integer), result[15:0] is the low half of the signed 16 by 16 product and the upper bits are zero. sat_hit is 1 exactly when the product lies outside -32768 to 32767.
- R6: With mode 4 (unsigned mixed), the result is a_in[7:0] times b_in[15:0] when that is at most 0xFFFF. Otherwise the result is 0xFFFF with sat_hit set.
- R7: Mode codes 5, 6 and 7 give a zero result and never raise sat_hit.
- R8: The 16-bit modes read only a_in[15:0] and b_in[15:0], and mode 4 reads only a_in[7:0] of the first operand. Upper operand bits have no effect on the result.
- R9: gen_ovf and acc_ovf are zero after reset. They change only at a clock edge where op_valid is 1. Once set, a bit stays set until reset.
- R10: A valid overflow in mode 0 or 1 with to_acc set sets acc_ovf[acc_sel] and leaves gen_ovf unchanged. Any other valid overflow sets gen_ovf.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe: operation is real, status may update |
| mode | input | 3 | Operation select (0 Q15, 1 Q31, 2 rounded Q15, 3 signed int16, 4 unsigned 8x16) |
| to_acc | input | 1 | Product is bound for an accumulator |
| acc_sel | input | 2 | Target accumulator index |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| result | output | 64 | Product, zero-extended for the narrower modes |
| sat_hit | output | 1 | Combinational overflow/saturation event for the current operands |
| gen_ovf | output | 1 | Sticky general overflow bit |
| acc_ovf | output | 4 | Sticky overflow bits, one per accumulator |

## Verification
The checker assumes that mode, to_acc, acc_sel and the operands carry known values at every clock edge. It also assumes that acc_sel names an accumulator that exists. The bench keeps to these assumptions by driving every input on the falling edge, holding it steady across the next rising edge, and using only the four legal accumulator indices. The checker further assumes that overflow status is observed only after the edge that captures it. The bench therefore reads the sticky bits just after a rising edge and reads the combinational result halfway through the cycle.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [2:0] {
    MD_Q15   = 3'd0,
    MD_Q31   = 3'd1,
    MD_RQ15  = 3'd2,
    MD_INT16 = 3'd3,
    MD_UMIX  = 3'd4
  } fmul_mode_e;

  // Doubled Q15 product, {overflow, value}
  function automatic logic [32:0] q15_double(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] sa;
    logic signed [31:0] sb;
    logic signed [31:0] pr;
    sa = {{16{a[15]}}, a};
    sb = {{16{b[15]}}, b};
    pr = sa * sb;
    if (a == 16'h8000 && b == 16'h8000) return {1'b1, 32'h7FFF_FFFF};
    return {1'b0, pr[30:0], 1'b0};
  endfunction

  // Doubled Q31 product, {overflow, value}
  function automatic logic [64:0] q31_double(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa;
    logic signed [63:0] sb;
    logic signed [63:0] pr;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    pr = sa * sb;
    if (a == 32'h8000_0000 && b == 32'h8000_0000)
      return {1'b1, 64'h7FFF_FFFF_FFFF_FFFF};
    return {1'b0, pr[62:0], 1'b0};
  endfunction

  // Rounded Q15 result, {overflow, value}
  function automatic logic [16:0] q15_round(input logic [15:0] a, input logic [15:0] b);
    logic [32:0] d;
    logic [31:0] t;
    d = q15_double(a, b);
    if (d[32]) return {1'b1, 16'h7FFF};
    t = d[31:0] + 32'h0000_8000;
    return {1'b0, t[31:16]};
  endfunction

  // Wrapping signed 16x16, {overflow, low half}
  function automatic logic [16:0] int16_mul(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] sa;
    logic signed [31:0] sb;
    logic signed [31:0] pr;
    logic               fits;
    sa = {{16{a[15]}}, a};
    sb = {{16{b[15]}}, b};
    pr = sa * sb;
    fits = (pr[31:15] == 17'h00000) || (pr[31:15] == 17'h1FFFF);
    return {~fits, pr[15:0]};
  endfunction

  // Clamping unsigned 8x16, {overflow, value}
  function automatic logic [16:0] umix_mul(input logic [7:0] a, input logic [15:0] b);
    logic [23:0] pr;
    pr = {16'h0000, a} * {8'h00, b};
    if (|pr[23:16]) return {1'b1, 16'hFFFF};
    return {1'b0, pr[15:0]};
  endfunction

endpackage

// File: rtl/fmul_core.sv
module fmul_core
  import fmul_pkg::*;
#(
  parameter int OPW = 32,
  localparam int RESW = 2 * OPW
) (
  input  logic [2:0]      mode,
  input  logic [OPW-1:0]  a_in,
  input  logic [OPW-1:0]  b_in,
  output logic [RESW-1:0] result,
  output logic            sat_hit,
  output logic            acc_capable
);

  logic [32:0] r_q15;
  logic [64:0] r_q31;
  logic [16:0] r_rnd;
  logic [16:0] r_int;
  logic [16:0] r_umx;

  assign r_q15 = q15_double(a_in[15:0], b_in[15:0]);
  assign r_q31 = q31_double(a_in, b_in);
  assign r_rnd = q15_round(a_in[15:0], b_in[15:0]);
  assign r_int = int16_mul(a_in[15:0], b_in[15:0]);
  assign r_umx = umix_mul(a_in[7:0], b_in[15:0]);

  always_comb begin
    result      = '0;
    sat_hit     = 1'b0;
    acc_capable = 1'b0;
    case (mode)
      MD_Q15: begin
        result[31:0] = r_q15[31:0];
        sat_hit      = r_q15[32];
        acc_capable  = 1'b1;
      end
      MD_Q31: begin
        result      = r_q31[63:0];
        sat_hit     = r_q31[64];
        acc_capable = 1'b1;
      end
      MD_RQ15: begin
        result[15:0] = r_rnd[15:0];
        sat_hit      = r_rnd[16];
      end
      MD_INT16: begin
        result[15:0] = r_int[15:0];
        sat_hit      = r_int[16];
      end
      MD_UMIX: begin
        result[15:0] = r_umx[15:0];
        sat_hit      = r_umx[16];
      end
      default: begin
        result  = '0;
        sat_hit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fmul_flags.sv
module fmul_flags #(
  parameter int NUM_ACC = 4,
  localparam int SELW = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic               sat_hit,
  input  logic               acc_capable,
  input  logic               to_acc,
  input  logic [SELW-1:0]    acc_sel,
  output logic               gen_ovf,
  output logic [NUM_ACC-1:0] acc_ovf
);

  logic take_ovf;
  logic route_acc;

  assign take_ovf  = op_valid & sat_hit;
  assign route_acc = to_acc & acc_capable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gen_ovf <= 1'b0;
    else if (take_ovf && !route_acc) gen_ovf <= 1'b1;
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        acc_ovf[g] <= 1'b0;
      else if (take_ovf && route_acc && (acc_sel == SELW'(g)))
        acc_ovf[g] <= 1'b1;
    end
  end

endmodule

// File: rtl/fmul_q_sat.sv
module fmul_q_sat #(
  parameter int OPW = 32,
  parameter int NUM_ACC = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            op_valid,
  input  logic [2:0]                      mode,
  input  logic                            to_acc,
  input  logic [$clog2(NUM_ACC)-1:0]      acc_sel,
  input  logic [OPW-1:0]                  a_in,
  input  logic [OPW-1:0]                  b_in,
  output logic [2*OPW-1:0]                result,
  output logic                            sat_hit,
  output logic                            gen_ovf,
  output logic [NUM_ACC-1:0]              acc_ovf
);

  logic acc_capable;

  fmul_core #(.OPW(OPW)) u_core (
    .mode        (mode),
    .a_in        (a_in),
    .b_in        (b_in),
    .result      (result),
    .sat_hit     (sat_hit),
    .acc_capable (acc_capable)
  );

  fmul_flags #(.NUM_ACC(NUM_ACC)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .sat_hit     (sat_hit),
    .acc_capable (acc_capable),
    .to_acc      (to_acc),
    .acc_sel     (acc_sel),
    .gen_ovf     (gen_ovf),
    .acc_ovf     (acc_ovf)
  );

endmodule

// File: rtl/fmul_q_sat_chk.sv
module fmul_q_sat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  mode,
  input logic        to_acc,
  input logic [1:0]  acc_sel,
  input logic [31:0] a_in,
  input logic [31:0] b_in,
  input logic [63:0] result,
  input logic        sat_hit,
  input logic        gen_ovf,
  input logic [3:0]  acc_ovf
);

  p_q15_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && a_in[15:0] == 16'h8000 && b_in[15:0] == 16'h8000)
      |-> (result == 64'h0000_0000_7FFF_FFFF && sat_hit));

  p_q31_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && a_in == 32'h8000_0000 && b_in == 32'h8000_0000)
      |-> (result == 64'h7FFF_FFFF_FFFF_FFFF && sat_hit));

  p_rnd_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && a_in[15:0] == 16'h8000 && b_in[15:0] == 16'h8000)
      |-> (result == 64'h7FFF && sat_hit));

  p_int_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> (result[63:16] == 48'h0));

  p_umix_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && sat_hit) |-> (result == 64'hFFFF));

  p_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > 3'd4) |-> (result == 64'h0 && !sat_hit));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(gen_ovf) && $stable(acc_ovf)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ovf |=> gen_ovf);

  p_acc_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sat_hit && to_acc && mode <= 3'd1)
      |=> (acc_ovf[$past(acc_sel)] && $stable(gen_ovf)));

  p_gen_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sat_hit && (!to_acc || mode > 3'd1))
      |=> (gen_ovf && $stable(acc_ovf)));

endmodule

bind fmul_q_sat fmul_q_sat_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .mode     (mode),
  .to_acc   (to_acc),
  .acc_sel  (acc_sel),
  .a_in     (a_in),
  .b_in     (b_in),
  .result   (result),
  .sat_hit  (sat_hit),
  .gen_ovf  (gen_ovf),
  .acc_ovf  (acc_ovf)
);

// File: tb/fmul_q_sat_bench.sv
module fmul_q_sat_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        to_acc = 1'b0;
  logic [1:0]  acc_sel = 2'd0;
  logic [31:0] a_in = '0;
  logic [31:0] b_in = '0;
  logic [63:0] result;
  logic        sat_hit;
  logic        gen_ovf;
  logic [3:0]  acc_ovf;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fmul_q_sat u_fmul_q_sat (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .mode(mode),
    .to_acc(to_acc), .acc_sel(acc_sel), .a_in(a_in), .b_in(b_in),
    .result(result), .sat_hit(sat_hit), .gen_ovf(gen_ovf), .acc_ovf(acc_ovf)
  );

  // {mode, a, b, expected result, expected sat_hit}
  localparam int NV = 22;
  localparam logic [131:0] VT [NV] = '{
    {3'd0, 32'h0000_4000, 32'h0000_4000, 64'h0000_0000_2000_0000, 1'b0}, // R1
    {3'd0, 32'h0000_8000, 32'h0000_8000, 64'h0000_0000_7FFF_FFFF, 1'b1}, // R2
    {3'd0, 32'h0000_8000, 32'h0000_7FFF, 64'h0000_0000_8001_0000, 1'b0}, // R1
    {3'd0, 32'h0000_FFFF, 32'h0000_0002, 64'h0000_0000_FFFF_FFFC, 1'b0}, // R1
    {3'd0, 32'hFFFF_8000, 32'hABCD_8000, 64'h0000_0000_7FFF_FFFF, 1'b1}, // R8
    {3'd1, 32'h4000_0000, 32'h4000_0000, 64'h2000_0000_0000_0000, 1'b0}, // R3
    {3'd1, 32'h8000_0000, 32'h8000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1}, // R3
    {3'd1, 32'hFFFF_FFFF, 32'h0000_0003, 64'hFFFF_FFFF_FFFF_FFFA, 1'b0}, // R3
    {3'd2, 32'h0000_4000, 32'h0000_4000, 64'h0000_0000_0000_2000, 1'b0}, // R4
    {3'd2, 32'h0000_8000, 32'h0000_8000, 64'h0000_0000_0000_7FFF, 1'b1}, // R4
    {3'd2, 32'h0000_0001, 32'h0000_4000, 64'h0000_0000_0000_0001, 1'b0}, // R4
    {3'd2, 32'h0000_0001, 32'h0000_3FFF, 64'h0000_0000_0000_0000, 1'b0}, // R4
    {3'd2, 32'h0000_FFFF, 32'h0000_4000, 64'h0000_0000_0000_0000, 1'b0}, // R4
    {3'd3, 32'h0000_0064, 32'h0000_0064, 64'h0000_0000_0000_2710, 1'b0}, // R5
    {3'd3, 32'h0000_0100, 32'h0000_0100, 64'h0000_0000_0000_0000, 1'b1}, // R5
    {3'd3, 32'h0000_FF00, 32'h0000_0080, 64'h0000_0000_0000_8000, 1'b0}, // R5
    {3'd3, 32'h0000_0080, 32'h0000_0100, 64'h0000_0000_0000_8000, 1'b1}, // R5
    {3'd4, 32'h0000_00FF, 32'h0000_0101, 64'h0000_0000_0000_FFFF, 1'b0}, // R6
    {3'd4, 32'h0000_0002, 32'h0000_8000, 64'h0000_0000_0000_FFFF, 1'b1}, // R6
    {3'd4, 32'hABCD_EF12, 32'h1234_0010, 64'h0000_0000_0000_0120, 1'b0}, // R8
    {3'd5, 32'h8000_0000, 32'h8000_0000, 64'h0000_0000_0000_0000, 1'b0}, // R7
    {3'd7, 32'h0000_8000, 32'h0000_8000, 64'h0000_0000_0000_0000, 1'b0}  // R7
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic eg, input logic [3:0] ea);
    chk(gen_ovf == eg && acc_ovf == ea, req, {59'h0, gen_ovf, acc_ovf}, {59'h0, eg, ea});
  endtask

  // Present a strobed op on the falling edge, let the rising edge capture it
  task automatic strobe(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
                        input logic ta, input logic [1:0] sel);
    @(negedge clk);
    mode = m; a_in = a; b_in = b; to_acc = ta; acc_sel = sel; op_valid = 1'b1;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_flags("R9 reset state", 1'b0, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk with op_valid low: results only
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VT[i][131:129];
      a_in = VT[i][128:97];
      b_in = VT[i][96:65];
      #1;
      chk(result == VT[i][64:1], $sformatf("R1-table result vec %0d", i), result, VT[i][64:1]);
      chk(sat_hit == VT[i][0], $sformatf("R2-table sat_hit vec %0d", i),
          {63'h0, sat_hit}, {63'h0, VT[i][0]});
    end
    @(posedge clk);
    #1;
    chk_flags("R9 no update without op_valid", 1'b0, 4'b0000);

    strobe(3'd0, 32'h8000, 32'h8000, 1'b1, 2'd2);
    chk_flags("R10 Q15 to accumulator 2", 1'b0, 4'b0100);

    strobe(3'd3, 32'h0100, 32'h0100, 1'b1, 2'd1);
    chk_flags("R10 integer overflow goes general", 1'b1, 4'b0100);

    strobe(3'd0, 32'h4000, 32'h4000, 1'b1, 2'd0);
    chk_flags("R9 sticky after clean op", 1'b1, 4'b0100);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_flags("R9 reset clears", 1'b0, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    strobe(3'd1, 32'h8000_0000, 32'h8000_0000, 1'b1, 2'd3);
    chk_flags("R10 Q31 to accumulator 3", 1'b0, 4'b1000);

    strobe(3'd2, 32'h8000, 32'h8000, 1'b1, 2'd0);
    chk_flags("R10 rounded mode goes general", 1'b1, 4'b1000);

    strobe(3'd0, 32'h8000, 32'h8000, 1'b0, 2'd1);
    chk_flags("R10 Q15 without to_acc", 1'b1, 4'b1000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule